// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives a NAND flash device from a short program that software loads into registers. A 32-bit instruction word holds eight 4-bit opcodes. Each opcode selects one device phase: send one of four stored command bytes, send a column, page or user address, move a block of bytes between an on-chip byte buffer and the device, move one or two bytes between a small data register and the device, or wait for the device's ready line before sending a command or reading a block.

Software writes the configuration registers through a simple write port, fills the byte buffer if a program phase needs it, and pulses `start`. The engine then walks the slots in order and emits one device cycle per clock on a generic byte bus (`dev_valid`, `dev_kind`, `dev_wbyte`, `dev_rbyte`). At the end it pulses `done`. If a wait step sees no ready within the programmed limit, it sets `err_timeout` and abandons the rest of the program. Pin timing and ECC belong to other blocks.

Top module: `nand_seq_top`

## Requirements
- R1: After reset `busy`, `done`, `err_timeout` and `dev_valid` are low, and `dev_valid` stays low whenever `busy` is low.
- R2: Slots run in order from the opcode in instruction bits 31:28 to the one in bits 3:0. A program with no 0x0 opcode ends after the slot in bits 3:0.
- R3: Opcodes 0x4, 0x5, 0x6 and 0x7 each send one byte with `dev_kind` 0. The byte is command field 0, 1, 2 or 3, and field k sits in command register bits (31-8k):(24-8k).
- R4: Opcode 0x1 sends the column register as COL_BYTES bytes (2 by default). Opcode 0x2 sends the page register as PAGE_BYTES bytes (3 by default). Opcode 0x3 sends the user-address byte. All address bytes go out least significant byte first with `dev_kind` 1.
- R5: Opcode 0x0 ends the program, and no later slot produces a device cycle. Opcode 0xF is skipped with no device cycle, and execution continues with the next slot.
- R6: Opcode 0x8 sends byte-count bytes from buffer locations 0 upward with `dev_kind` 2. Opcode 0xA performs byte-count reads with `dev_kind` 3 and stores each `dev_rbyte` into buffer locations 0 upward.
- R7: A byte count of 0 makes opcodes 0x8, 0xA and 0xE finish with no data cycle, and the next slot follows.
- R8: Opcode 0x9 sends the data register and opcode 0xB reads into it. One byte moves when mode bit 0 is 0 and two when it is 1, low byte (bits 7:0) first.
- R9: Opcodes 0xC, 0xD and 0xE produce no device cycle while `dev_ready` is low. Once it is high they send command field 0, send command field 1, or perform a byte-count block read into the buffer, respectively.
- R10: If `dev_ready` stays low for timeout-limit+1 consecutive wait cycles, `err_timeout` rises together with `done`, and the remaining slots are skipped. The flag holds until the next accepted start clears it.
- R11: While `busy` is high, register writes, host buffer writes and `start` have no effect.
- R12: An accepted `start` raises `busy` on the next cycle. `done` is high for exactly one cycle at the end of each program, and `busy` falls on the following cycle.
- R13: `cfg_sel` chooses the register written: 0 instruction, 1 command, 2 column, 3 page, 4 user address (bits 7:0), 5 byte count (bits 11:0), 6 data register (bits 15:0), 7 mode (bit 0 selects two short bytes, bits 31:16 hold the timeout limit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (R13) |
| cfg_wdata | input | 32 | Register write data |
| start | input | 1 | Starts the program when idle |
| buf_we | input | 1 | Host buffer write strobe |
| buf_addr | input | BUF_AW | Host buffer address for write and read |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_rdata | output | 8 | Host buffer read byte at `buf_addr` |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-program pulse |
| err_timeout | output | 1 | Wait step timed out |
| data_reg | output | 16 | Current data register value |
| dev_valid | output | 1 | Device cycle this clock |
| dev_kind | output | 2 | 0 command, 1 address, 2 write data, 3 read |
| dev_wbyte | output | 8 | Byte sent to the device |
| dev_rbyte | input | 8 | Byte returned by the device on a read cycle |
| dev_ready | input | 1 | Device ready (high) or busy (low) |

## Verification
The properties assume that `start`, `cfg_we`, `buf_we` and `dev_ready` are never unknown once reset is released. They also assume `start` is an ordinary level sampled on every clock, so a start held across the done cycle would simply launch a new program. The stimulus drives every input on the falling edge, pulses `start` for one cycle only, and changes `dev_ready` only between programs or from a branch that runs beside the program and raises it after a fixed delay. The device model answers reads with a byte derived from a running read count, so the bench can predict both order and contents.

// File: rtl/nfs_pkg.sv
// Package: shared types and opcode decode for the NAND command sequencer.
// Assumes opcodes are 4 bits wide and device cycle kinds fit in 2 bits.
package nfs_pkg;

    typedef enum logic [1:0] {
        DK_CMD   = 2'd0,
        DK_ADDR  = 2'd1,
        DK_WDATA = 2'd2,
        DK_RDATA = 2'd3
    } dev_kind_e;

    typedef enum logic [2:0] {
        SRC_CMD  = 3'd0,
        SRC_COL  = 3'd1,
        SRC_PAGE = 3'd2,
        SRC_USER = 3'd3,
        SRC_BUF  = 3'd4,
        SRC_DREG = 3'd5
    } byte_src_e;

    typedef enum logic [2:0] {
        LEN_ONE   = 3'd0,
        LEN_COL   = 3'd1,
        LEN_PAGE  = 3'd2,
        LEN_SHORT = 3'd3,
        LEN_COUNT = 3'd4
    } len_sel_e;

    typedef struct packed {
        logic      ends;
        logic      active;
        logic      wait_rdy;
        dev_kind_e kind;
        byte_src_e src;
        logic [1:0] cmd_sel;
        len_sel_e  len;
    } op_desc_t;

    // Map one opcode onto the phase it performs
    function automatic op_desc_t decode_op(input logic [3:0] op);
        op_desc_t d;
        d = '0;
        case (op)
            4'h0: d.ends = 1'b1;
            4'h1: begin d.active = 1'b1; d.kind = DK_ADDR;  d.src = SRC_COL;  d.len = LEN_COL;   end
            4'h2: begin d.active = 1'b1; d.kind = DK_ADDR;  d.src = SRC_PAGE; d.len = LEN_PAGE;  end
            4'h3: begin d.active = 1'b1; d.kind = DK_ADDR;  d.src = SRC_USER; d.len = LEN_ONE;   end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                d.active  = 1'b1;
                d.kind    = DK_CMD;
                d.src     = SRC_CMD;
                d.cmd_sel = op[1:0];
                d.len     = LEN_ONE;
            end
            4'h8: begin d.active = 1'b1; d.kind = DK_WDATA; d.src = SRC_BUF;  d.len = LEN_COUNT; end
            4'h9: begin d.active = 1'b1; d.kind = DK_WDATA; d.src = SRC_DREG; d.len = LEN_SHORT; end
            4'hA: begin d.active = 1'b1; d.kind = DK_RDATA; d.src = SRC_BUF;  d.len = LEN_COUNT; end
            4'hB: begin d.active = 1'b1; d.kind = DK_RDATA; d.src = SRC_DREG; d.len = LEN_SHORT; end
            4'hC, 4'hD: begin
                d.active   = 1'b1;
                d.wait_rdy = 1'b1;
                d.kind     = DK_CMD;
                d.src      = SRC_CMD;
                d.cmd_sel  = {1'b0, op[0]};
                d.len      = LEN_ONE;
            end
            4'hE: begin
                d.active   = 1'b1;
                d.wait_rdy = 1'b1;
                d.kind     = DK_RDATA;
                d.src      = SRC_BUF;
                d.len      = LEN_COUNT;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/nfs_regfile.sv
// Module: configuration registers of the sequencer.
// Assumes software writes only while the engine is idle; writes during a
// run are dropped. The engine alone updates the data register during a run.
module nfs_regfile #(
    parameter int CNT_W = 12,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             lock,
    input  logic             eng_dreg_we,
    input  logic             eng_dreg_idx,
    input  logic [7:0]       eng_dreg_byte,
    output logic [31:0]      instr,
    output logic [31:0]      cmd,
    output logic [31:0]      col,
    output logic [31:0]      page,
    output logic [7:0]       user_addr,
    output logic [CNT_W-1:0] count,
    output logic [15:0]      dreg,
    output logic             short_two,
    output logic [TO_W-1:0]  to_limit
);

    // Register update from the host port or the engine's short reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr     <= '0;
            cmd       <= '0;
            col       <= '0;
            page      <= '0;
            user_addr <= '0;
            count     <= '0;
            dreg      <= '0;
            short_two <= 1'b0;
            to_limit  <= '0;
        end else if (eng_dreg_we) begin
            if (eng_dreg_idx) dreg[15:8] <= eng_dreg_byte;
            else              dreg[7:0]  <= eng_dreg_byte;
        end else if (cfg_we && !lock) begin
            case (cfg_sel)
                3'd0: instr     <= cfg_wdata;
                3'd1: cmd       <= cfg_wdata;
                3'd2: col       <= cfg_wdata;
                3'd3: page      <= cfg_wdata;
                3'd4: user_addr <= cfg_wdata[7:0];
                3'd5: count     <= cfg_wdata[CNT_W-1:0];
                3'd6: dreg      <= cfg_wdata[15:0];
                default: begin
                    short_two <= cfg_wdata[0];
                    to_limit  <= cfg_wdata[16 +: TO_W];
                end
            endcase
        end
    end

endmodule

// File: rtl/nfs_buffer.sv
// Module: byte buffer with one write port and two asynchronous read ports.
// Assumes the caller arbitrates the single write port.
module nfs_buffer #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] mem [DEPTH];

    // Store one byte per cycle
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read both ports combinationally
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end

endmodule

// File: rtl/nfs_ready_timer.sv
// Module: counts not-ready cycles of a wait step and flags the limit.
// Assumes clear is pulsed before each wait step begins.
module nfs_ready_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            tick,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);

    logic [TO_W-1:0] cnt_q;

    // Count cycles spent waiting
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + 1'b1;
    end

    // Flag when the wait has used its allowance
    always_comb expired = (cnt_q == limit);

endmodule

// File: rtl/nfs_step_ctrl.sv
// Module: walks the eight opcode slots and emits one device cycle per clock.
// Assumes the registers are stable while busy (the register file locks them)
// and that COL_BYTES and PAGE_BYTES are between 1 and 4.
module nfs_step_ctrl
    import nfs_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int BUF_AW     = 8,
    parameter int COL_BYTES  = 2,
    parameter int PAGE_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [31:0]       cmd,
    input  logic [31:0]       col,
    input  logic [31:0]       page,
    input  logic [7:0]        user_addr,
    input  logic [CNT_W-1:0]  count,
    input  logic [15:0]       dreg,
    input  logic              short_two,
    input  logic              dev_ready,
    input  logic [7:0]        dev_rbyte,
    input  logic [7:0]        buf_rbyte,
    input  logic              tmr_expired,
    output logic              busy,
    output logic              done,
    output logic              err_timeout,
    output logic              dev_valid,
    output logic [1:0]        dev_kind,
    output logic [7:0]        dev_wbyte,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wbyte,
    output logic              dreg_we,
    output logic              dreg_idx,
    output logic [7:0]        dreg_byte,
    output logic              tmr_clear,
    output logic              tmr_tick
);

    localparam int SLOT_W = 3;
    localparam logic [SLOT_W-1:0] LAST_SLOT = 3'd7;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_DECODE = 3'd1,
        S_WAIT   = 3'd2,
        S_ISSUE  = 3'd3,
        S_FINISH = 3'd4
    } state_e;

    state_e            state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [CNT_W-1:0]  idx_q, idx_d;
    logic [CNT_W-1:0]  len_q, len_d;
    dev_kind_e         kind_q, kind_d;
    byte_src_e         src_q, src_d;
    logic [1:0]        sel_q, sel_d;
    logic              err_q, err_d;
    logic              adv;

    logic [3:0]        cur_op;
    op_desc_t          dec;
    logic [CNT_W-1:0]  dec_len;

    // Pick the opcode of the current slot, slot 0 in the top nibble
    always_comb cur_op = instr[(7 - int'(slot_q)) * 4 +: 4];

    // Decode it and work out how many device cycles it needs
    always_comb begin
        dec = decode_op(cur_op);
        case (dec.len)
            LEN_COL:   dec_len = CNT_W'(COL_BYTES);
            LEN_PAGE:  dec_len = CNT_W'(PAGE_BYTES);
            LEN_SHORT: dec_len = short_two ? CNT_W'(2) : CNT_W'(1);
            LEN_COUNT: dec_len = count;
            default:   dec_len = CNT_W'(1);
        endcase
    end

    // Next-state logic of the slot walker
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        idx_d   = idx_q;
        len_d   = len_q;
        kind_d  = kind_q;
        src_d   = src_q;
        sel_d   = sel_q;
        err_d   = err_q;
        adv     = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (start) begin
                    slot_d  = '0;
                    err_d   = 1'b0;
                    state_d = S_DECODE;
                end
            end
            S_DECODE: begin
                if (dec.ends) begin
                    state_d = S_FINISH;
                end else if (!dec.active) begin
                    adv = 1'b1;
                end else begin
                    kind_d = dec.kind;
                    src_d  = dec.src;
                    sel_d  = dec.cmd_sel;
                    len_d  = dec_len;
                    idx_d  = '0;
                    if (dec.wait_rdy)      state_d = S_WAIT;
                    else if (dec_len == 0) adv = 1'b1;
                    else                   state_d = S_ISSUE;
                end
            end
            S_WAIT: begin
                if (dev_ready) begin
                    if (len_q == 0) adv = 1'b1;
                    else            state_d = S_ISSUE;
                end else if (tmr_expired) begin
                    err_d   = 1'b1;
                    state_d = S_FINISH;
                end
            end
            S_ISSUE: begin
                if (idx_q == len_q - 1'b1) adv = 1'b1;
                else                       idx_d = idx_q + 1'b1;
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
        if (adv) begin
            if (slot_q == LAST_SLOT) begin
                state_d = S_FINISH;
            end else begin
                slot_d  = slot_q + 1'b1;
                state_d = S_DECODE;
            end
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            slot_q  <= '0;
            idx_q   <= '0;
            len_q   <= '0;
            kind_q  <= DK_CMD;
            src_q   <= SRC_CMD;
            sel_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            idx_q   <= idx_d;
            len_q   <= len_d;
            kind_q  <= kind_d;
            src_q   <= src_d;
            sel_q   <= sel_d;
            err_q   <= err_d;
        end
    end

    // Select the outgoing byte for the current device cycle
    always_comb begin
        case (src_q)
            SRC_CMD:  dev_wbyte = cmd[(3 - int'(sel_q)) * 8 +: 8];
            SRC_COL:  dev_wbyte = col[int'(idx_q[1:0]) * 8 +: 8];
            SRC_PAGE: dev_wbyte = page[int'(idx_q[1:0]) * 8 +: 8];
            SRC_USER: dev_wbyte = user_addr;
            SRC_BUF:  dev_wbyte = buf_rbyte;
            SRC_DREG: dev_wbyte = idx_q[0] ? dreg[15:8] : dreg[7:0];
            default:  dev_wbyte = '0;
        endcase
    end

    // Drive status, device strobes and the capture paths for reads
    always_comb begin
        busy        = (state_q != S_IDLE);
        done        = (state_q == S_FINISH);
        err_timeout = err_q;
        dev_valid   = (state_q == S_ISSUE);
        dev_kind    = kind_q;
        buf_addr    = idx_q[BUF_AW-1:0];
        buf_we      = dev_valid && (kind_q == DK_RDATA) && (src_q == SRC_BUF);
        buf_wbyte   = dev_rbyte;
        dreg_we     = dev_valid && (kind_q == DK_RDATA) && (src_q == SRC_DREG);
        dreg_idx    = idx_q[0];
        dreg_byte   = dev_rbyte;
        tmr_clear   = (state_q == S_DECODE);
        tmr_tick    = (state_q == S_WAIT) && !dev_ready;
    end

endmodule

// File: rtl/nand_seq_top.sv
// Module: top of the NAND command sequencer; joins registers, buffer,
// ready timer and slot walker. Assumes one device cycle per clock, with pin
// timing handled outside. Host buffer writes are dropped while busy.
module nand_seq_top #(
    parameter int CNT_W      = 12,
    parameter int BUF_DEPTH  = 256,
    parameter int TO_W       = 16,
    parameter int COL_BYTES  = 2,
    parameter int PAGE_BYTES = 3,
    localparam int BUF_AW    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              start,
    input  logic              buf_we,
    input  logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    output logic [7:0]        buf_rdata,
    output logic              busy,
    output logic              done,
    output logic              err_timeout,
    output logic [15:0]       data_reg,
    output logic              dev_valid,
    output logic [1:0]        dev_kind,
    output logic [7:0]        dev_wbyte,
    input  logic [7:0]        dev_rbyte,
    input  logic              dev_ready
);

    logic [31:0]       instr, cmd, col, page;
    logic [7:0]        user_addr;
    logic [CNT_W-1:0]  count;
    logic              short_two;
    logic [TO_W-1:0]   to_limit;
    logic              eng_buf_we, eng_dreg_we, eng_dreg_idx;
    logic [BUF_AW-1:0] eng_buf_addr;
    logic [7:0]        eng_buf_wbyte, eng_dreg_byte, eng_buf_rbyte;
    logic              tmr_clear, tmr_tick, tmr_expired;
    logic              mem_we;
    logic [BUF_AW-1:0] mem_waddr;
    logic [7:0]        mem_wdata;

    nfs_regfile #(.CNT_W(CNT_W), .TO_W(TO_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .lock          (busy),
        .eng_dreg_we   (eng_dreg_we),
        .eng_dreg_idx  (eng_dreg_idx),
        .eng_dreg_byte (eng_dreg_byte),
        .instr         (instr),
        .cmd           (cmd),
        .col           (col),
        .page          (page),
        .user_addr     (user_addr),
        .count         (count),
        .dreg          (data_reg),
        .short_two     (short_two),
        .to_limit      (to_limit)
    );

    // Give the buffer write port to the engine while a program runs
    always_comb begin
        mem_we    = busy ? eng_buf_we    : buf_we;
        mem_waddr = busy ? eng_buf_addr  : buf_addr;
        mem_wdata = busy ? eng_buf_wbyte : buf_wdata;
    end

    nfs_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (eng_buf_addr),
        .rdata_a (eng_buf_rbyte),
        .raddr_b (buf_addr),
        .rdata_b (buf_rdata)
    );

    nfs_ready_timer #(.TO_W(TO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .tick    (tmr_tick),
        .limit   (to_limit),
        .expired (tmr_expired)
    );

    nfs_step_ctrl #(
        .CNT_W      (CNT_W),
        .BUF_AW     (BUF_AW),
        .COL_BYTES  (COL_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .instr       (instr),
        .cmd         (cmd),
        .col         (col),
        .page        (page),
        .user_addr   (user_addr),
        .count       (count),
        .dreg        (data_reg),
        .short_two   (short_two),
        .dev_ready   (dev_ready),
        .dev_rbyte   (dev_rbyte),
        .buf_rbyte   (eng_buf_rbyte),
        .tmr_expired (tmr_expired),
        .busy        (busy),
        .done        (done),
        .err_timeout (err_timeout),
        .dev_valid   (dev_valid),
        .dev_kind    (dev_kind),
        .dev_wbyte   (dev_wbyte),
        .buf_we      (eng_buf_we),
        .buf_addr    (eng_buf_addr),
        .buf_wbyte   (eng_buf_wbyte),
        .dreg_we     (eng_dreg_we),
        .dreg_idx    (eng_dreg_idx),
        .dreg_byte   (eng_dreg_byte),
        .tmr_clear   (tmr_clear),
        .tmr_tick    (tmr_tick)
    );

endmodule

// File: rtl/nfs_checker.sv
// Module: protocol properties of the sequencer's status and device strobes.
// Assumes inputs are known once reset is released.
module nfs_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic err_timeout,
    input logic dev_valid
);

    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dev_valid); // R1

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R12

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R12

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R11

    AST_NO_BUS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dev_valid); // R12

    AST_ERR_RISES_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> done); // R10

    AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(err_timeout)); // R10

endmodule

bind nand_seq_top nfs_checker u_nfs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .err_timeout (err_timeout),
    .dev_valid   (dev_valid)
);

// File: tb/tb_nand_seq_top.sv
`timescale 1ns/1ps
module tb_nand_seq_top;

    localparam int BUF_AW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_sel = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              start = 1'b0;
    logic              buf_we = 1'b0;
    logic [BUF_AW-1:0] buf_addr = '0;
    logic [7:0]        buf_wdata = '0;
    logic [7:0]        buf_rdata;
    logic              busy, done, err_timeout;
    logic [15:0]       data_reg;
    logic              dev_valid;
    logic [1:0]        dev_kind;
    logic [7:0]        dev_wbyte;
    logic [7:0]        dev_rbyte;
    logic              dev_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    // Device model and bus log
    int        rd_cnt = 0;
    logic      prev_rd = 1'b0;
    int        log_n = 0;
    logic [9:0] log_e [512];
    int        exp_n = 0;
    logic [9:0] exp_e [64];

    always #2.5 clk = ~clk;

    assign dev_rbyte = 8'h30 + rd_cnt[7:0];

    nand_seq_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .busy(busy), .done(done), .err_timeout(err_timeout),
        .data_reg(data_reg), .dev_valid(dev_valid), .dev_kind(dev_kind),
        .dev_wbyte(dev_wbyte), .dev_rbyte(dev_rbyte), .dev_ready(dev_ready)
    );

    // Record every device cycle at the falling edge
    always @(negedge clk) begin
        if (prev_rd) rd_cnt = rd_cnt + 1;
        prev_rd = dev_valid && (dev_kind == 2'd3);
        if (dev_valid && log_n < 512) begin
            log_e[log_n] = {dev_kind, (dev_kind == 2'd3) ? dev_rbyte : dev_wbyte};
            log_n = log_n + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic host_buf_write(input int a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = BUF_AW'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic host_buf_read(input int a, output logic [7:0] d);
        @(negedge clk);
        buf_addr = BUF_AW'(a);
        #1 d = buf_rdata;
    endtask

    // Pulse start and follow the run until busy drops
    task automatic run_seq(output int ndone, output logic busy_early);
        int ncyc;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_early = busy;
        ndone = 0;
        ncyc = 0;
        while (ncyc < 5000) begin
            if (done) ndone++;
            if (!busy) break;
            @(negedge clk);
            ncyc++;
        end
    endtask

    task automatic exp_clear();
        exp_n = 0;
    endtask

    task automatic exp_push(input logic [1:0] k, input logic [7:0] b);
        exp_e[exp_n] = {k, b};
        exp_n++;
    endtask

    task automatic check_log(input int base, input string req);
        chk((log_n - base) == exp_n, req, log_n - base, exp_n);
        for (int i = 0; i < exp_n; i++) begin
            if (base + i < log_n)
                chk(log_e[base + i] == exp_e[i], req, int'(log_e[base + i]), int'(exp_e[i]));
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err_timeout && !dev_valid, "R1 reset state",
            {busy, done, err_timeout, dev_valid}, 0);
    endtask

    // Commands and all address forms in slot order
    task automatic t_addr_cmd();
        int base, nd; logic be;
        cfg_write(3'd1, 32'h1122_3344);
        cfg_write(3'd2, 32'h0000_0A5C);
        cfg_write(3'd3, 32'h0012_3456);
        cfg_write(3'd4, 32'h0000_007E);
        cfg_write(3'd0, 32'h4123_5000);
        base = log_n;
        run_seq(nd, be);
        exp_clear();
        exp_push(0, 8'h11);
        exp_push(1, 8'h5C); exp_push(1, 8'h0A);
        exp_push(1, 8'h56); exp_push(1, 8'h34); exp_push(1, 8'h12);
        exp_push(1, 8'h7E);
        exp_push(0, 8'h22);
        check_log(base, "R2 R3 R4 R13 address and command order");
        chk(nd == 1, "R12 one done pulse", nd, 1);
        chk(be, "R12 busy after start", be, 1);
    endtask

    task automatic t_eight_slots();
        int base, nd; logic be;
        cfg_write(3'd0, 32'h4567_4567);
        base = log_n;
        run_seq(nd, be);
        exp_clear();
        for (int r = 0; r < 2; r++) begin
            exp_push(0, 8'h11); exp_push(0, 8'h22); exp_push(0, 8'h33); exp_push(0, 8'h44);
        end
        check_log(base, "R2 R3 eight slots");
        chk(nd == 1, "R12 done after last slot", nd, 1);
    endtask

    task automatic t_nop_reserved();
        int base, nd; logic be;
        cfg_write(3'd0, 32'h4056_0000);
        base = log_n;
        run_seq(nd, be);
        exp_clear(); exp_push(0, 8'h11);
        check_log(base, "R5 nop ends");
        cfg_write(3'd0, 32'h4F50_0000);
        base = log_n;
        run_seq(nd, be);
        exp_clear(); exp_push(0, 8'h11); exp_push(0, 8'h22);
        check_log(base, "R5 0xF skipped");
    endtask

    task automatic t_bulk();
        int base, nd, rb; logic be; logic [7:0] d;
        for (int i = 0; i < 5; i++) host_buf_write(i, 8'hC0 + 8'(i));
        cfg_write(3'd5, 32'd5);
        cfg_write(3'd0, 32'h8000_0000);
        base = log_n;
        run_seq(nd, be);
        exp_clear();
        for (int i = 0; i < 5; i++) exp_push(2, 8'hC0 + 8'(i));
        check_log(base, "R6 bulk write");
        cfg_write(3'd5, 32'd4);
        cfg_write(3'd0, 32'hA000_0000);
        base = log_n; rb = rd_cnt;
        run_seq(nd, be);
        exp_clear();
        for (int i = 0; i < 4; i++) exp_push(3, 8'h30 + 8'(rb + i));
        check_log(base, "R6 bulk read cycles");
        for (int i = 0; i < 4; i++) begin
            host_buf_read(i, d);
            chk(d == 8'h30 + 8'(rb + i), "R6 bulk read stored", d, 8'h30 + 8'(rb + i));
        end
        host_buf_read(4, d);
        chk(d == 8'hC4, "R6 byte past count untouched", d, 8'hC4);
    endtask

    task automatic t_zero_count();
        int base, nd; logic be;
        cfg_write(3'd5, 32'd0);
        cfg_write(3'd0, 32'h48AE_5000);
        base = log_n;
        run_seq(nd, be);
        exp_clear(); exp_push(0, 8'h11); exp_push(0, 8'h22);
        check_log(base, "R7 zero count");
    endtask

    task automatic t_short();
        int base, nd, rb; logic be;
        cfg_write(3'd6, 32'h0000_BEEF);
        cfg_write(3'd7, {16'd20, 15'd0, 1'b0});
        cfg_write(3'd0, 32'h9000_0000);
        base = log_n;
        run_seq(nd, be);
        exp_clear(); exp_push(2, 8'hEF);
        check_log(base, "R8 short write one byte");
        cfg_write(3'd7, {16'd20, 15'd0, 1'b1});
        base = log_n;
        run_seq(nd, be);
        exp_clear(); exp_push(2, 8'hEF); exp_push(2, 8'hBE);
        check_log(base, "R8 short write two bytes");
        cfg_write(3'd0, 32'hB000_0000);
        rb = rd_cnt;
        run_seq(nd, be);
        chk(data_reg == {8'h30 + 8'(rb + 1), 8'h30 + 8'(rb)}, "R8 short read",
            data_reg, {8'h30 + 8'(rb + 1), 8'h30 + 8'(rb)});
    endtask

    task automatic t_wait();
        int base, nd, rb; logic be; logic quiet;
        cfg_write(3'd7, {16'd20, 16'd0});
        cfg_write(3'd5, 32'd3);
        cfg_write(3'd0, 32'hCDE0_0000);
        dev_ready = 1'b0;
        base = log_n; rb = rd_cnt;
        quiet = 1'b0;
        fork
            run_seq(nd, be);
            begin
                repeat (8) @(negedge clk);
                quiet = (log_n == base);
                dev_ready = 1'b1;
            end
        join
        chk(quiet, "R9 no cycles while not ready", log_n - base, 0);
        exp_clear();
        exp_push(0, 8'h11); exp_push(0, 8'h22);
        for (int i = 0; i < 3; i++) exp_push(3, 8'h30 + 8'(rb + i));
        check_log(base, "R9 wait then command or read");
        chk(!err_timeout, "R9 no timeout", err_timeout, 0);
    endtask

    task automatic t_timeout();
        int base, nd; logic be;
        cfg_write(3'd7, {16'd10, 16'd0});
        cfg_write(3'd0, 32'h4C50_0000);
        dev_ready = 1'b0;
        base = log_n;
        run_seq(nd, be);
        exp_clear(); exp_push(0, 8'h11);
        check_log(base, "R10 abort after timeout");
        chk(err_timeout, "R10 flag set", err_timeout, 1);
        chk(nd == 1, "R10 done on timeout", nd, 1);
        dev_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(err_timeout, "R10 flag held idle", err_timeout, 1);
        cfg_write(3'd0, 32'h5000_0000);
        base = log_n;
        run_seq(nd, be);
        exp_clear(); exp_push(0, 8'h22);
        check_log(base, "R10 next run");
        chk(!err_timeout, "R10 flag cleared by start", err_timeout, 0);
    endtask

    task automatic t_locked();
        int base, nd; logic be; logic [7:0] d;
        host_buf_write(0, 8'h5A);
        cfg_write(3'd7, {16'd100, 16'd0});
        cfg_write(3'd0, 32'hC000_0000);
        dev_ready = 1'b0;
        base = log_n;
        fork
            run_seq(nd, be);
            begin
                repeat (3) @(negedge clk);
                cfg_write(3'd1, 32'h9900_0000);
                host_buf_write(0, 8'hEE);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                dev_ready = 1'b1;
            end
        join
        exp_clear(); exp_push(0, 8'h11);
        check_log(base, "R11 command write ignored while busy");
        host_buf_read(0, d);
        chk(d == 8'h5A, "R11 buffer write ignored while busy", d, 8'h5A);
        chk(nd == 1, "R11 start ignored while busy", nd, 1);
        repeat (2) @(negedge clk);
        chk(!busy, "R11 no second run", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: act=hung exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_cmd();
        t_eight_slots();
        t_nop_reserved();
        t_bulk();
        t_zero_count();
        t_short();
        t_wait();
        t_timeout();
        t_locked();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule